// File: doc/BRIEF.md
# Serial Sampling-Converter Host Frame Controller

This block is the host side of a three-wire link to a 12-bit successive-approximation converter. It runs from the system clock and generates an active-low chip select together with a divided serial clock that idles high. It reads the converter's serial data line and presents each 12-bit result on a result bus with a one-cycle valid pulse. Frames run either once per start request (single-shot) or back to back (continuous).

Each frame holds chip select low for sixteen serial clocks. The host samples on serial-clock rising edges because the converter changes its data on falling edges. Only the bits taken at rising edges 4 to 15 become the result. This removes the leading zeros, and it removes the extra zero that can appear when chip select falls while the serial clock is high.

The time with chip select high between frames is a whole number of serial-clock periods. It is derived at elaboration from the acquisition time, the quiet time and a minimum frame length, all given in system-clock cycles. After reset the block runs one dummy frame whose data is never delivered. A low-power mode ends the frame early, after the 12th serial-clock fall. The result of such a frame is marked as truncated.

Top module: `sar_serial_host`

## Requirements
- R1: While reset is high, cs_n and sclk are 1 and valid is 0.
- R2: The first frame after reset is a dummy frame that never raises valid. The next frame starts no sooner than a full frame period after the dummy frame's chip-select fall.
- R3: While cs_n is high, sclk is 1. A full-length frame gives exactly 16 sclk rising edges, one every 2*DIV_HALF system cycles. cs_n stays low for 33*DIV_HALF cycles.
- R4: The result is made of the sdata values sampled at sclk rising edges 4 through 15 of the frame, most significant bit first. The values sampled at rising edges 1 to 3 and 16 have no effect on the result.
- R5: valid is high for exactly one cycle. In a full frame it rises 30*DIV_HALF cycles after cs_n falls. result and trunc keep their values until the next valid pulse.
- R6: In continuous mode, consecutive chip-select falls are 34*DIV_HALF + GAP cycles apart. GAP is the largest of ACQ_CYC, QUIET_CYC and FRAME_SCLKS*2*DIV_HALF - 34*DIV_HALF, rounded up to a multiple of 2*DIV_HALF. With the default parameters the spacing is 210 cycles.
- R7: With cont low, one frame starts per start pulse, and no frame starts without a request. A request made while a frame or gap is running is held until it can be served.
- R8: If lp_mode is high when a frame starts, cs_n rises 25*DIV_HALF cycles after its fall, after 12 sclk rising edges. valid rises 24*DIV_HALF cycles after the fall. result is the 9 bits from rising edges 4 to 12 in bits [11:3], with bits [2:0] zero, and trunc is 1. Full-length frames give trunc 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-shot frame request pulse |
| cont | input | 1 | Continuous back-to-back frames when high |
| lp_mode | input | 1 | Shortened low-power frame for frames started while high |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle high |
| result | output | 12 | Last delivered conversion code |
| trunc | output | 1 | Last result came from a shortened frame |
| valid | output | 1 | One-cycle pulse when result updates |

## Verification
A wrong half-period counter shows up within one frame. The count of sclk rising edges, the cycle at which valid rises and the length of the chip-select low window all move by whole half periods. A wrong capture window shifts or corrupts the code at the first valid pulse, and the garbage ones that the bench drives outside bits 4 to 15 make this easy to see. Faults in the gap counter or the request flags change the spacing between chip-select falls, or start frames nobody asked for, within a single gap. A dummy-frame flag that is cleared too early produces a valid pulse about 150 cycles after reset.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;

    localparam int RES_BITS       = 12;
    localparam int FIRST_DATA_BIT = 4;
    localparam int FULL_LAST_TOG  = 32;
    localparam int LP_LAST_TOG    = 24;
    localparam int FULL_LAST_BIT  = 15;
    localparam int LP_LAST_BIT    = 12;
    localparam int FULL_HALVES    = FULL_LAST_TOG + 2;
    localparam int LP_KEPT_BITS   = LP_LAST_BIT - FIRST_DATA_BIT + 1;

    typedef enum logic [1:0] {
        ST_READY  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_GAP    = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic strobe;
        logic last;
        logic dummy;
        logic lp;
    } cap_ctl_t;

    typedef struct packed {
        logic [RES_BITS-1:0] code;
        logic                trunc;
    } sample_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int gap_cycles(input int div_half, input int acq,
                                      input int quiet, input int frame_sclks);
        int need;
        int per;
        per  = 2 * div_half;
        need = imax(acq, quiet);
        need = imax(need, frame_sclks * per - FULL_HALVES * div_half);
        need = imax(need, per);
        return ((need + per - 1) / per) * per;
    endfunction

endpackage

// File: rtl/sar_half_timer.sv
module sar_half_timer #(
    parameter int DIV_HALF = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == CNT_TOP) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sar_frame_seq.sv
module sar_frame_seq
    import sar_host_pkg::*;
#(
    parameter int GAP_CYC = 40
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     start,
    input  logic     cont,
    input  logic     lp_mode,
    output logic     run,
    output logic     cs_n,
    output logic     sclk,
    output cap_ctl_t cap
);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam int HW = GW + 2;
    localparam logic [GW-1:0] GAP_TOP = GW'(GAP_CYC - 1);
    localparam logic [HW-1:0] HI_MAX  = {HW{1'b1}};

    seq_state_e    state;
    logic [5:0]    half;
    logic [5:0]    nh;
    logic [5:0]    last_tog;
    logic [4:0]    last_bit;
    logic [4:0]    bit_idx;
    logic [GW-1:0] gap_cnt;
    logic          gap_done;
    logic          pend;
    logic          dummy_pend;
    logic          dummy_q;
    logic          lp_q;
    logic          begin_frame;
    logic          cs_q;
    logic          sclk_q;

    assign nh       = half + 6'd1;
    assign bit_idx  = nh[5:1];
    assign last_tog = lp_q ? 6'(LP_LAST_TOG) : 6'(FULL_LAST_TOG);
    assign last_bit = lp_q ? 5'(LP_LAST_BIT) : 5'(FULL_LAST_BIT);
    assign gap_done = (state == ST_GAP) && (gap_cnt == GAP_TOP);
    assign run      = (state == ST_ACTIVE);
    assign cs_n     = cs_q;
    assign sclk     = sclk_q;

    always_comb begin
        begin_frame = 1'b0;
        if (state == ST_READY) begin
            begin_frame = dummy_pend || cont || pend || start;
        end else if (gap_done) begin
            begin_frame = cont || pend || start;
        end
    end

    always_comb begin
        cap.strobe = run && tick && !nh[0] && (nh <= last_tog) &&
                     (bit_idx >= 5'(FIRST_DATA_BIT)) && (bit_idx <= last_bit);
        cap.last   = cap.strobe && (bit_idx == last_bit);
        cap.dummy  = dummy_q;
        cap.lp     = lp_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_READY;
            half       <= '0;
            gap_cnt    <= '0;
            pend       <= 1'b0;
            dummy_pend <= 1'b1;
            dummy_q    <= 1'b0;
            lp_q       <= 1'b0;
            cs_q       <= 1'b1;
            sclk_q     <= 1'b1;
        end else if (begin_frame) begin
            state      <= ST_ACTIVE;
            half       <= '0;
            cs_q       <= 1'b0;
            sclk_q     <= 1'b1;
            dummy_q    <= dummy_pend;
            lp_q       <= dummy_pend ? 1'b0 : lp_mode;
            pend       <= dummy_pend ? (pend || start) : 1'b0;
            dummy_pend <= 1'b0;
        end else begin
            pend <= pend || start;
            case (state)
                ST_ACTIVE: begin
                    if (tick) begin
                        half <= nh;
                        if (nh <= last_tog) sclk_q <= ~sclk_q;
                        if (nh == last_tog + 6'd1) cs_q <= 1'b1;
                        if (nh == last_tog + 6'd2) begin
                            state   <= ST_GAP;
                            gap_cnt <= '0;
                        end
                    end
                end
                ST_GAP: begin
                    gap_cnt <= gap_cnt + 1'b1;
                    if (gap_done) state <= ST_READY;
                end
                default: ;
            endcase
        end
    end

    // Checker state: how long chip select has been high.
    logic [HW-1:0] hi_cnt;
    logic          armed;
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
            armed  <= 1'b0;
        end else begin
            hi_cnt <= !cs_q ? '0 : ((hi_cnt == HI_MAX) ? hi_cnt : hi_cnt + 1'b1);
            if (!cs_q) armed <= 1'b1;
        end
    end

    assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    assert_gap_kept_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(cs_n) && armed) |-> (hi_cnt >= HW'(GAP_CYC)));

    assert_no_idle_capture_R4: assert property (@(posedge clk) disable iff (rst)
        cap.strobe |-> !cs_n);
endmodule

// File: rtl/sar_bit_capture.sv
module sar_bit_capture
    import sar_host_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  cap_ctl_t            cap,
    input  logic                sdata,
    output logic [RES_BITS-1:0] result,
    output logic                trunc,
    output logic                valid
);
    logic [RES_BITS-1:0] sh;
    logic [RES_BITS-1:0] nxt;
    sample_t             held;

    assign nxt    = {sh[RES_BITS-2:0], sdata};
    assign result = held.code;
    assign trunc  = held.trunc;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            held  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (cap.strobe) sh <= nxt;
            if (cap.last && !cap.dummy) begin
                valid <= 1'b1;
                if (cap.lp) begin
                    held.code  <= {nxt[LP_KEPT_BITS-1:0], {(RES_BITS-LP_KEPT_BITS){1'b0}}};
                    held.trunc <= 1'b1;
                end else begin
                    held.code  <= nxt;
                    held.trunc <= 1'b0;
                end
            end
        end
    end

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !valid |-> ($stable(result) && $stable(trunc)));

    assert_trunc_zero_low_R8: assert property (@(posedge clk) disable iff (rst)
        (valid && trunc) |-> (result[RES_BITS-LP_KEPT_BITS-1:0] == '0));
endmodule

// File: rtl/sar_serial_host.sv
module sar_serial_host
    import sar_host_pkg::*;
#(
    parameter int DIV_HALF    = 5,
    parameter int ACQ_CYC     = 35,
    parameter int QUIET_CYC   = 5,
    parameter int FRAME_SCLKS = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        cont,
    input  logic        lp_mode,
    input  logic        sdata,
    output logic        cs_n,
    output logic        sclk,
    output logic [11:0] result,
    output logic        trunc,
    output logic        valid
);
    localparam int GAP_CYC = gap_cycles(DIV_HALF, ACQ_CYC, QUIET_CYC, FRAME_SCLKS);

    logic     run;
    logic     tick;
    cap_ctl_t cap;

    sar_half_timer #(.DIV_HALF(DIV_HALF)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    sar_frame_seq #(.GAP_CYC(GAP_CYC)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .start   (start),
        .cont    (cont),
        .lp_mode (lp_mode),
        .run     (run),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .cap     (cap)
    );

    sar_bit_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .cap    (cap),
        .sdata  (sdata),
        .result (result),
        .trunc  (trunc),
        .valid  (valid)
    );

    assert_dummy_silent_R2: assert property (@(posedge clk) disable iff (rst)
        valid |-> !cap.dummy);

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (!valid && sclk));
endmodule

// File: tb/sim_sar_serial_host.sv
module sim_sar_serial_host;
    localparam int DIV    = 5;
    localparam int PERIOD = 210;
    localparam int LAT_F  = 30 * DIV;
    localparam int LAT_LP = 24 * DIV;
    localparam int LOW_F  = 33 * DIV;
    localparam int LOW_LP = 25 * DIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic cont = 1'b0;
    logic lp_mode = 1'b0;
    logic sdata = 1'b0;
    logic cs_n;
    logic sclk;
    logic [11:0] result;
    logic trunc;
    logic valid;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sar_serial_host #(.DIV_HALF(DIV)) u0 (
        .clk(clk), .rst(rst), .start(start), .cont(cont), .lp_mode(lp_mode),
        .sdata(sdata), .cs_n(cs_n), .sclk(sclk), .result(result),
        .trunc(trunc), .valid(valid)
    );

    // Converter model: drives bit k after the k-th sclk fall; ones outside 4..15.
    logic [11:0] conv_word = 12'h000;
    int fcnt = 0;
    always @(negedge cs_n) begin
        fcnt  = 0;
        sdata = 1'b0;
    end
    always @(negedge sclk) begin
        if (!cs_n) begin
            fcnt = fcnt + 1;
            sdata = (fcnt >= 4 && fcnt <= 15) ? conv_word[15 - fcnt] : 1'b1;
        end
    end

    // Port monitor, sampled at the falling clock edge.
    int cyc = 0, fall_cyc = 0, rise_cyc = 0, prev_fall = 0;
    int rises = 0, last_rises = 0, n_falls = 0, n_ups = 0, n_valid = 0;
    int valid_cyc = 0, idle_bad = 0, dbl = 0, hold_bad = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b1, prev_valid = 1'b0;
    logic [11:0] prev_res = '0;
    logic prev_tr = 1'b0;
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst) begin
            if (prev_cs && !cs_n) begin
                prev_fall = fall_cyc; fall_cyc = cyc; rises = 0; n_falls++;
            end
            if (!prev_cs && cs_n) begin
                rise_cyc = cyc; last_rises = rises; n_ups++;
            end
            if (!cs_n && !prev_sclk && sclk) rises++;
            if (cs_n && !sclk) idle_bad++;
            if (valid) begin
                n_valid++; valid_cyc = cyc;
                if (prev_valid) dbl++;
            end else if (result != prev_res || trunc != prev_tr) begin
                hold_bad++;
            end
        end
        prev_cs = cs_n; prev_sclk = sclk; prev_valid = valid;
        prev_res = result; prev_tr = trunc;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_falls(input int n);
        int target = n_falls + n;
        for (int i = 0; i < 5000 && n_falls < target; i++) step();
    endtask

    task automatic wait_up();
        int target = n_ups + 1;
        for (int i = 0; i < 5000 && n_ups < target; i++) step();
    endtask

    task automatic wait_valid();
        int target = n_valid + 1;
        for (int i = 0; i < 5000 && n_valid < target; i++) step();
    endtask

    task automatic t_reset();
        repeat (4) step();
        chk(cs_n === 1'b1, "R1 cs_n in reset", int'(cs_n), 1);
        chk(sclk === 1'b1, "R1 sclk in reset", int'(sclk), 1);
        chk(valid === 1'b0, "R1 valid in reset", int'(valid), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_boot();
        int f0;
        conv_word = 12'hA5C;
        wait_falls(1);
        f0 = fall_cyc;
        pulse_start();
        wait_up();
        chk(n_valid == 0, "R2 dummy frame silent", n_valid, 0);
        chk(last_rises == 16, "R3 dummy rising edges", last_rises, 16);
        wait_falls(1);
        chk(fall_cyc - f0 == PERIOD, "R2 gap after dummy", fall_cyc - f0, PERIOD);
        wait_valid();
        chk(result == 12'hA5C, "R4 first result", int'(result), 'hA5C);
        chk(valid_cyc - fall_cyc == LAT_F, "R5 valid latency", valid_cyc - fall_cyc, LAT_F);
        wait_up();
    endtask

    task automatic t_word(input logic [11:0] w);
        conv_word = w;
        pulse_start();
        wait_valid();
        chk(result == w, "R4 result code", int'(result), int'(w));
        chk(trunc == 1'b0, "R8 full frame trunc", int'(trunc), 0);
        chk(valid_cyc - fall_cyc == LAT_F, "R5 valid latency", valid_cyc - fall_cyc, LAT_F);
        wait_up();
        chk(last_rises == 16, "R3 rising edges", last_rises, 16);
        chk(rise_cyc - fall_cyc == LOW_F, "R3 cs low window", rise_cyc - fall_cyc, LOW_F);
    endtask

    task automatic t_idle();
        int nf = n_falls;
        logic [11:0] r = result;
        repeat (400) step();
        chk(n_falls == nf, "R7 no frame without request", n_falls - nf, 0);
        chk(result == r, "R5 result held while idle", int'(result), int'(r));
    endtask

    task automatic t_cont();
        int nf;
        int nv;
        conv_word = 12'h5A3;
        @(negedge clk);
        cont = 1'b1;
        wait_falls(2);
        for (int k = 0; k < 3; k++) begin
            wait_falls(1);
            chk(fall_cyc - prev_fall == PERIOD, "R6 continuous spacing", fall_cyc - prev_fall, PERIOD);
        end
        wait_valid();
        chk(result == 12'h5A3, "R6 continuous result", int'(result), 'h5A3);
        @(negedge clk);
        cont = 1'b0;
        repeat (500) step();
        nf = n_falls;
        nv = n_valid;
        repeat (500) step();
        chk(n_falls == nf, "R7 continuous stops", n_falls - nf, 0);
        chk(n_valid == nv, "R7 no stray valid", n_valid - nv, 0);
    endtask

    task automatic t_lp();
        conv_word = 12'hB6D;
        @(negedge clk);
        lp_mode = 1'b1;
        pulse_start();
        wait_valid();
        chk(result == 12'hB68, "R8 truncated code", int'(result), 'hB68);
        chk(trunc == 1'b1, "R8 trunc flag", int'(trunc), 1);
        chk(valid_cyc - fall_cyc == LAT_LP, "R8 valid latency", valid_cyc - fall_cyc, LAT_LP);
        wait_up();
        chk(last_rises == 12, "R8 rising edges", last_rises, 12);
        chk(rise_cyc - fall_cyc == LOW_LP, "R8 cs low window", rise_cyc - fall_cyc, LOW_LP);
        @(negedge clk);
        lp_mode = 1'b0;
        repeat (100) step();
        t_word(12'h7E1);
    endtask

    task automatic t_final();
        chk(idle_bad == 0, "R3 sclk high while cs_n high", idle_bad, 0);
        chk(dbl == 0, "R5 single-cycle valid", dbl, 0);
        chk(hold_bad == 0, "R5 result stable between pulses", hold_bad, 0);
    endtask

    initial begin
        t_reset();
        t_boot();
        t_word(12'h000);
        t_word(12'hFFF);
        t_word(12'h801);
        t_word(12'h3C7);
        t_idle();
        t_cont();
        t_lp();
        t_final();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule